// File: doc/BRIEF.md
# Microcoded Two-Operand ALU Instruction Executor

This block carries out the family of two-operand arithmetic and logic instructions. An opcode is accepted when its bits 7:6 are both zero and bit 2 is zero. The block takes the opcode together with an operand selector: a register field, an r/m field and a flag that says whether the r/m operand lives in memory. The value of a memory operand is supplied along with the start pulse, because address generation and the memory read happen elsewhere. The block then walks a short fixed micro-sequence. The first step stages the destination operand in temporary register A. The second stages the source operand in temporary register B. The third runs the ALU, updates the flags and writes a register result.

When the destination is a register, the instruction finishes in step 3, and the done strobe tells the surrounding machine that the next instruction may start. When the destination is memory, a fourth step raises a write request. That request holds until the memory side acknowledges it. The register file is external and is reached through one combinational read port and one write port. Byte operations use the low byte of each register.

Top module: `alu_microseq`

## Requirements
- R1: An opcode is accepted only when `start` is high, the block is idle, opcode[7:6]=00 and opcode[2]=0. Any other opcode causes no register write, no memory request, no done pulse and no flag change.
- R2: Opcode[5:3] selects the operation: 000 ADD, 001 OR, 010 ADC, 011 SBB, 100 AND, 101 SUB, 110 XOR, 111 CMP. The result is destination op source.
- R3: Opcode[0]=0 selects a byte operation, which uses bits 7:0 of each operand. Its result is written with `rf_wbyte`/`mem_wr_byte` high and upper data bits zero. Opcode[0]=1 selects a 16-bit word operation.
- R4: Opcode[1]=0 makes the r/m operand the destination and the register field the source. Opcode[1]=1 makes the register field the destination and the r/m operand the source. The r/m operand is memory (value `mem_rdata` at acceptance) when `rm_is_mem` is high.
- R5: In the first cycle after acceptance, `rf_raddr` selects the destination register. In the second, it selects the source register. For a register destination, the third cycle drives `rf_we` and `done` for exactly one cycle, and the block is idle again in the fourth.
- R6: For a memory destination, the third cycle raises neither `rf_we` nor `done`. From the fourth cycle, `mem_wr_req` stays high with stable data until `mem_wr_ack` is seen. `done` is high in the acknowledge cycle, and the request drops after it.
- R7: CMP updates flags but writes neither a register nor memory. It finishes with `done` in the third cycle whatever the destination.
- R8: `flags` = {OF,SF,ZF,CF} at the selected width, updated only at the end of the third cycle. CF is the carry or borrow out. ZF means the result is zero. SF is the result's top bit. OF is signed overflow. OR, AND and XOR clear CF and OF. Reset clears flags to 0.
- R9: ADC adds the current CF as carry-in, and SBB subtracts the current CF as borrow-in.
- R10: A start pulse during a busy instruction is ignored. `done` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present |
| opcode | input | 8 | Instruction opcode |
| reg_sel | input | RA | Register-field operand index |
| rm_sel | input | RA | r/m register index (when not memory) |
| rm_is_mem | input | 1 | r/m operand is in memory |
| mem_rdata | input | 16 | Memory operand value, sampled at acceptance |
| rf_raddr | output | RA | Register file read address |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RA | Register write address |
| rf_wdata | output | 16 | Register write data |
| rf_wbyte | output | 1 | Write low byte only |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_data | output | 16 | Memory write data |
| mem_wr_byte | output | 1 | Memory write is byte-sized |
| mem_wr_ack | input | 1 | Memory write acknowledge |
| flags | output | 4 | {OF,SF,ZF,CF} |
| done | output | 1 | Instruction complete, next may start |

## Verification
If `start` is accepted at edge 0, the read addresses are due in the cycles after edges 0 and 1. The register write and done for a register or CMP destination are due after edge 2. The new flags are visible after edge 3. A memory request is due after edge 3 and lasts until the acknowledge cycle. The bench drives inputs on the falling edge and samples 1 ns later. Its reference model computes each result with integer arithmetic. It then checks every output on each of those cycles and also on idle cycles, where nothing may be driven and the flags must hold.

// File: rtl/alu_microseq.sv
module alu_microseq #(
  parameter int RA = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [RA-1:0] reg_sel,
  input  logic [RA-1:0] rm_sel,
  input  logic          rm_is_mem,
  input  logic [15:0]   mem_rdata,
  output logic [RA-1:0] rf_raddr,
  input  logic [15:0]   rf_rdata,
  output logic          rf_we,
  output logic [RA-1:0] rf_waddr,
  output logic [15:0]   rf_wdata,
  output logic          rf_wbyte,
  output logic          mem_wr_req,
  output logic [15:0]   mem_wr_data,
  output logic          mem_wr_byte,
  input  logic          mem_wr_ack,
  output logic [3:0]    flags,
  output logic          done
);

  localparam logic [2:0] OP_ADD = 3'd0, OP_OR  = 3'd1, OP_ADC = 3'd2, OP_SBB = 3'd3,
                         OP_AND = 3'd4, OP_SUB = 3'd5, OP_XOR = 3'd6, OP_CMP = 3'd7;

  typedef enum logic [2:0] {ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4} st_t;
  st_t state;

  logic [2:0]    op_q;
  logic          wide_q, dir_q, mem_q;
  logic [RA-1:0] reg_q, rm_q;
  logic [15:0]   mdata_q, tmpa, tmpb, res_q;

  logic accept, step3, dst_mem, src_mem, is_cmp;
  logic [RA-1:0] dst_reg, src_reg;

  assign accept  = start && state == ST_IDLE && opcode[7:6] == 2'b00 && !opcode[2];
  assign step3   = state == ST_S3;
  assign dst_mem = !dir_q && mem_q;
  assign src_mem = dir_q && mem_q;
  assign dst_reg = dir_q ? reg_q : rm_q;
  assign src_reg = dir_q ? rm_q : reg_q;
  assign is_cmp  = op_q == OP_CMP;

  assign rf_raddr = (state == ST_S2) ? src_reg : dst_reg;

  logic [15:0] a, b, r;
  logic [16:0] sum17, diff17;
  logic cin, cf_n, of_n, sf_n, zf_n, am, bm, rm, is_sub, is_add;

  assign a   = wide_q ? tmpa : {8'h00, tmpa[7:0]};
  assign b   = wide_q ? tmpb : {8'h00, tmpb[7:0]};
  assign cin = (op_q == OP_ADC || op_q == OP_SBB) ? flags[0] : 1'b0;
  assign sum17  = {1'b0, a} + {1'b0, b} + {16'h0000, cin};
  assign diff17 = {1'b0, a} - {1'b0, b} - {16'h0000, cin};
  assign is_add = op_q == OP_ADD || op_q == OP_ADC;
  assign is_sub = op_q == OP_SUB || op_q == OP_SBB || op_q == OP_CMP;

  always_comb begin
    case (op_q)
      OP_OR:   r = a | b;
      OP_AND:  r = a & b;
      OP_XOR:  r = a ^ b;
      OP_ADD, OP_ADC: r = sum17[15:0];
      default: r = diff17[15:0];
    endcase
    if (!wide_q) r[15:8] = 8'h00;
  end

  assign am   = wide_q ? a[15] : a[7];
  assign bm   = wide_q ? b[15] : b[7];
  assign rm   = wide_q ? r[15] : r[7];
  assign sf_n = rm;
  assign zf_n = wide_q ? (r == 16'h0000) : (r[7:0] == 8'h00);
  assign cf_n = is_add ? (wide_q ? sum17[16] : sum17[8]) :
                is_sub ? (wide_q ? diff17[16] : diff17[8]) : 1'b0;
  assign of_n = is_add ? (am == bm && rm != am) :
                is_sub ? (am != bm && rm != am) : 1'b0;

  assign rf_we       = step3 && !dst_mem && !is_cmp;
  assign rf_waddr    = dst_reg;
  assign rf_wdata    = r;
  assign rf_wbyte    = !wide_q;
  assign mem_wr_req  = state == ST_S4;
  assign mem_wr_data = res_q;
  assign mem_wr_byte = !wide_q;
  assign done        = (step3 && (!dst_mem || is_cmp)) || (mem_wr_req && mem_wr_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      flags   <= 4'h0;
      op_q    <= 3'd0;
      wide_q  <= 1'b0;
      dir_q   <= 1'b0;
      mem_q   <= 1'b0;
      reg_q   <= '0;
      rm_q    <= '0;
      mdata_q <= 16'h0000;
      tmpa    <= 16'h0000;
      tmpb    <= 16'h0000;
      res_q   <= 16'h0000;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q    <= opcode[5:3];
          wide_q  <= opcode[0];
          dir_q   <= opcode[1];
          mem_q   <= rm_is_mem;
          reg_q   <= reg_sel;
          rm_q    <= rm_sel;
          mdata_q <= mem_rdata;
          state   <= ST_S1;
        end
        ST_S1: begin
          tmpa  <= dst_mem ? mdata_q : rf_rdata;
          state <= ST_S2;
        end
        ST_S2: begin
          tmpb  <= src_mem ? mdata_q : rf_rdata;
          state <= ST_S3;
        end
        ST_S3: begin
          flags <= {of_n, sf_n, zf_n, cf_n};
          res_q <= r;
          state <= (dst_mem && !is_cmp) ? ST_S4 : ST_IDLE;
        end
        ST_S4: if (mem_wr_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/alu_microseq_chk.sv
module alu_microseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        rf_we,
  input logic        mem_wr_req,
  input logic        mem_wr_ack,
  input logic [15:0] mem_wr_data,
  input logic [3:0]  flags,
  input logic [2:0]  op_q,
  input logic        step3
);

  p_excl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_wr_req));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data)));

  p_ack_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |-> done);

  p_reg_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);

  p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || mem_wr_req) |-> (op_q != 3'd7));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step3 |=> $stable(flags));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind alu_microseq alu_microseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .rf_we(rf_we), .mem_wr_req(mem_wr_req),
  .mem_wr_ack(mem_wr_ack), .mem_wr_data(mem_wr_data), .flags(flags),
  .op_q(op_q), .step3(step3)
);

// File: tb/alu_microseq_bench.sv
module alu_microseq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rm_is_mem = 1'b0, mem_wr_ack = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [2:0] reg_sel = 3'd0, rm_sel = 3'd0;
  logic [15:0] mem_rdata = 16'h0000;
  logic [2:0] rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_wr_data;
  logic rf_we, rf_wbyte, mem_wr_req, mem_wr_byte, done;
  logic [3:0] flags;

  int checks = 0, errors = 0;
  logic [15:0] regs [8];
  logic [3:0] exp_flags = 4'h0;

  always #4 clk = ~clk;

  alu_microseq u_alu_microseq (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .reg_sel(reg_sel),
    .rm_sel(rm_sel), .rm_is_mem(rm_is_mem), .mem_rdata(mem_rdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_wbyte(rf_wbyte), .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data),
    .mem_wr_byte(mem_wr_byte), .mem_wr_ack(mem_wr_ack), .flags(flags), .done(done)
  );

  assign rf_rdata = regs[rf_raddr];

  always @(posedge clk)
    if (rf_we) begin
      if (rf_wbyte) regs[rf_waddr][7:0] <= rf_wdata[7:0];
      else          regs[rf_waddr] <= rf_wdata;
    end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference ALU: integer arithmetic at the chosen width
  task automatic ref_alu(input logic [2:0] o, input logic w, input logic [15:0] av,
                         input logic [15:0] bv, input logic c,
                         output logic [15:0] res, output logic [3:0] fl);
    int mask, top, a, b, t, r;
    logic cf, of, add, sub;
    mask = w ? 32'hFFFF : 32'hFF;
    top  = w ? 32'h8000 : 32'h80;
    a = int'(av) & mask;
    b = int'(bv) & mask;
    add = (o == 0 || o == 2);
    sub = (o == 3 || o == 5 || o == 7);
    case (o)
      0: t = a + b;
      1: t = a | b;
      2: t = a + b + int'(c);
      3: t = a - b - int'(c);
      4: t = a & b;
      5, 7: t = a - b;
      default: t = a ^ b;
    endcase
    r = t & mask;
    cf = add ? (t > mask) : sub ? (t < 0) : 1'b0;
    of = add ? (((a & top) == (b & top)) && ((r & top) != (a & top))) :
         sub ? (((a & top) != (b & top)) && ((r & top) != (a & top))) : 1'b0;
    res = 16'(r);
    fl = {of, (r & top) != 0, r == 0, cf};
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      check({tag, " done"}, done, 0);
      check({tag, " rf_we"}, rf_we, 0);
      check({tag, " mem_wr_req"}, mem_wr_req, 0);
      check({tag, " flags"}, flags, exp_flags);
    end
  endtask

  task automatic run(string tag, logic [7:0] op, logic [2:0] rg, logic [2:0] rmv,
                     logic ismem, logic [15:0] md, int lat, logic poke);
    logic w, d, dmem, cmp;
    logic [15:0] av, bv, res;
    logic [3:0] fl;
    logic [2:0] dreg, sreg;
    w = op[0]; d = op[1];
    dmem = !d && ismem;
    cmp = op[5:3] == 3'd7;
    dreg = d ? rg : rmv;
    sreg = d ? rmv : rg;
    av = dmem ? md : regs[dreg];
    bv = (d && ismem) ? md : regs[sreg];
    ref_alu(op[5:3], w, av, bv, exp_flags[0], res, fl);

    @(negedge clk);
    start = 1; opcode = op; reg_sel = rg; rm_sel = rmv; rm_is_mem = ismem; mem_rdata = md;
    @(negedge clk); start = 0; mem_rdata = 16'hDEAD; #1;
    if (!dmem) check({tag, " R5 dst raddr"}, rf_raddr, dreg);
    check({tag, " R5 s1 done"}, done, 0);
    @(negedge clk);
    if (poke) begin start = 1; opcode = 8'h01; reg_sel = 3'd7; end
    #1;
    if (!(d && ismem)) check({tag, " R5 src raddr"}, rf_raddr, sreg);
    check({tag, " R5 s2 done"}, done, 0);
    @(negedge clk); start = 0; #1;
    check({tag, " R5/R6/R7 s3 rf_we"}, rf_we, !dmem && !cmp);
    check({tag, " R6/R7 s3 done"}, done, !dmem || cmp);
    check({tag, " R7 s3 mem_wr_req"}, mem_wr_req, 0);
    check({tag, " R8 flags not yet"}, flags, exp_flags);
    if (!dmem && !cmp) begin
      check({tag, " R4 waddr"}, rf_waddr, dreg);
      check({tag, " R2/R3 wdata"}, rf_wdata, res);
      check({tag, " R3 wbyte"}, rf_wbyte, !w);
    end
    exp_flags = fl;
    if (dmem && !cmp) begin
      for (int k = 0; k <= lat; k++) begin
        @(negedge clk);
        mem_wr_ack = (k == lat);
        #1;
        check({tag, " R6 req held"}, mem_wr_req, 1);
        check({tag, " R6 done at ack"}, done, k == lat);
        check({tag, " R2/R3 mem data"}, mem_wr_data, res);
        check({tag, " R3 mem byte"}, mem_wr_byte, !w);
        check({tag, " R6 no rf_we"}, rf_we, 0);
        check({tag, " R8 flags"}, flags, exp_flags);
      end
      @(negedge clk); mem_wr_ack = 0; #1;
      check({tag, " R6 req dropped"}, mem_wr_req, 0);
      check({tag, " R10 done single"}, done, 0);
    end else begin
      @(negedge clk); #1;
      check({tag, " R8 flags"}, flags, exp_flags);
      check({tag, " R10 done single"}, done, 0);
      check({tag, " R5 rf_we single"}, rf_we, 0);
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'(16'h1111 * (i + 1));
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset flags", flags, 0);
    check("R5 reset done", done, 0);
    check("R6 reset req", mem_wr_req, 0);
    rst_n = 1;
    regs[0] = 16'h7FFF; regs[1] = 16'h0001; regs[2] = 16'h00F0; regs[3] = 16'h0F10;
    run("R2 ADD word overflow", 8'h03, 3'd0, 3'd1, 0, 0, 0, 0);
    idle(1, "R2 gap");
    check("R2 ADD written", regs[0], 16'h8000);
    run("R3 ADD byte carry", 8'h00, 3'd2, 3'd3, 0, 0, 0, 0);
    check("R3 byte keeps upper", regs[3], 16'h0F00);
    run("R9 ADC with CF", 8'h13, 3'd1, 3'd1, 0, 0, 0, 0);
    run("R2 SUB word borrow", 8'h2B, 3'd1, 3'd0, 0, 0, 0, 0);
    run("R9 SBB with CF", 8'h1B, 3'd4, 3'd5, 0, 0, 0, 0);
    run("R2 OR word", 8'h0B, 3'd6, 3'd2, 0, 0, 0, 0);
    run("R2 AND byte", 8'h22, 3'd7, 3'd3, 0, 0, 0, 0);
    run("R2 XOR zero", 8'h33, 3'd5, 3'd5, 0, 0, 0, 0);
    run("R7 CMP reg", 8'h3B, 3'd4, 3'd6, 0, 0, 0, 0);
    run("R6 ADD mem word", 8'h01, 3'd2, 3'd0, 1, 16'hFFF0, 2, 0);
    run("R6 SUB mem byte", 8'h28, 3'd0, 3'd0, 1, 16'h1280, 0, 0);
    run("R7 CMP mem dst", 8'h39, 3'd1, 3'd0, 1, 16'h0001, 1, 0);
    run("R4 mem source", 8'h03, 3'd3, 3'd0, 1, 16'h8001, 0, 0);
    run("R10 start while busy", 8'h09, 3'd2, 3'd4, 0, 0, 0, 1);
    idle(3, "R10 poke ignored");
    @(negedge clk); start = 1; opcode = 8'h05; @(negedge clk); start = 0;
    idle(4, "R1 bit2 set ignored");
    @(negedge clk); start = 1; opcode = 8'h41; @(negedge clk); start = 0;
    idle(4, "R1 bit6 set ignored");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule